// File: doc/BRIEF.md
# Waveform Timer Channel with Capture and Compare

A single 16-bit timer channel with two operating modes. In waveform mode it counts selected clock ticks up, or up and then down, compares the count against three thresholds, and drives two outputs. Each output has its own action for every event source. In capture mode it latches the running count into two capture registers when two external inputs rise. The prescaled ticks come from outside as single-cycle enables, and one of them is chosen by a select input. A burst input pauses counting while it is low. A sticky status vector collects overflow, compare and capture events, and a read strobe clears it.

The counter advances only when the channel is enabled (`start_i`) and has been started by a trigger. A trigger is either the software trigger or, in waveform mode, a rising edge on `ext_i`. An RC match can restart the count, stop the clock, or disable the channel. A trigger always clears the counter and sets the direction to up. This includes the up/down modes, and it holds while burst is low. A capture always stores the exact count value.

Top module: `wave_timer`

## Requirements
- R1: After reset the count, both capture registers, the status vector and both waveform outputs are zero, and `clk_run_o` is low.
- R2: While enabled and started, and with `burst_i` high, the count changes by exactly one on each clock cycle in which `tick_i[clk_sel_i]` is high. Ticks on unselected lines have no effect.
- R3: While `burst_i` is low, the selected tick is masked and the count holds its value.
- R4: In up counting, the count wraps from 0xFFFF to 0 and sets status bit 0 (overflow). With RC restart selected (`wave_sel_i[1]`=1 in waveform mode, or `rc_trg_i`=1 in capture mode), the count returns to 0 on the first tick after it has reached `rc_i`.
- R5: In up/down counting (`wave_sel_i[0]`=1), the count turns down at 0xFFFF and continues through 0xFFFE without setting overflow. It turns up again at 0. In mode 3 it also turns down on reaching `rc_i`.
- R6: A trigger (`sw_trig_i`, or a rising edge of `ext_i` in waveform mode) clears the count to 0 on the next clock edge in every mode, whatever the tick and burst are doing. It sets the direction to up and starts the clock.
- R7: A rising edge of `cap_a_i` or `cap_b_i` in capture mode loads the count value present in that cycle into `cap_ra_o` or `cap_rb_o`. This holds with burst low, with a tick in the same cycle, and at an RC restart. It sets status bit 4 or bit 5 respectively.
- R8: Status bits 1, 2 and 3 (compare A, B, C) are set when a counting tick moves the count onto `ra_i`, `rb_i` or `rc_i`. A trigger that loads 0 never sets them. Compares A and B apply in waveform mode only.
- R9: On an RC compare, `rc_stop_i` stops the clock and `rc_dis_i` disables the channel. A later trigger restarts a stopped channel. A disabled channel needs `start_i` before a trigger can restart it.
- R10: `act_a_i` and `act_b_i` each hold four 2-bit actions: [7:6] software trigger, [5:4] external event, [3:2] RC compare, [1:0] own compare (A for `act_a_i`, B for `act_b_i`). The codes are 0 none, 1 set, 2 clear, 3 toggle.
- R11: When several output events coincide, the first one whose action is not none wins, in the order software trigger, external event, RC compare, own compare. An action of none never blocks a lower event.
- R12: `sr_rd_i` clears the status vector. A flag event in the same cycle as the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | NCLK | Single-cycle tick enables, one per prescaled clock |
| clk_sel_i | input | $clog2(NCLK) | Selects the counting tick |
| burst_i | input | 1 | Counting is allowed only while high |
| start_i | input | 1 | Enables the channel |
| halt_i | input | 1 | Disables the channel |
| sw_trig_i | input | 1 | Software trigger |
| ext_i | input | 1 | External event, rising edge, waveform mode |
| cap_a_i | input | 1 | Capture A input, rising edge, capture mode |
| cap_b_i | input | 1 | Capture B input, rising edge, capture mode |
| wave_mode_i | input | 1 | 1 waveform mode, 0 capture mode |
| wave_sel_i | input | 2 | Bit 0 up/down, bit 1 RC restart |
| rc_trg_i | input | 1 | RC restart in capture mode |
| rc_stop_i | input | 1 | Stop the clock on RC compare |
| rc_dis_i | input | 1 | Disable the channel on RC compare |
| ra_i | input | W | Compare A value |
| rb_i | input | W | Compare B value |
| rc_i | input | W | Compare C value |
| act_a_i | input | 8 | Output A action fields |
| act_b_i | input | 8 | Output B action fields |
| sr_rd_i | input | 1 | Status read strobe |
| count_o | output | W | Counter value |
| cap_ra_o | output | W | Capture A register |
| cap_rb_o | output | W | Capture B register |
| status_o | output | 6 | {ldB, ldA, cmpC, cmpB, cmpA, ovf} |
| clk_run_o | output | 1 | Channel enabled and clock running |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |

## Verification
The hardest states to reach are the two ends of the 16-bit range. The overflow wrap and the up/down turn at 0xFFFF both need the counter walked there from zero. The stimulus holds the selected tick high for 65,535 consecutive cycles, once in up mode and once in up/down mode, and then checks the next step. Coinciding events are set up by placing `ra_i` equal to `rc_i`, by pulsing `sw_trig_i` and `ext_i` together, and by asserting a capture edge in the same cycle as a tick or an RC restart.

// File: rtl/wave_timer.sv
module wave_timer #(
  parameter int W    = 16,
  parameter int NCLK = 4,
  localparam int SW  = $clog2(NCLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCLK-1:0] tick_i,
  input  logic [SW-1:0] clk_sel_i,
  input  logic          burst_i,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic          sw_trig_i,
  input  logic          ext_i,
  input  logic          cap_a_i,
  input  logic          cap_b_i,
  input  logic          wave_mode_i,
  input  logic [1:0]    wave_sel_i,
  input  logic          rc_trg_i,
  input  logic          rc_stop_i,
  input  logic          rc_dis_i,
  input  logic [W-1:0]  ra_i,
  input  logic [W-1:0]  rb_i,
  input  logic [W-1:0]  rc_i,
  input  logic [7:0]    act_a_i,
  input  logic [7:0]    act_b_i,
  input  logic          sr_rd_i,
  output logic [W-1:0]  count_o,
  output logic [W-1:0]  cap_ra_o,
  output logic [W-1:0]  cap_rb_o,
  output logic [5:0]    status_o,
  output logic          clk_run_o,
  output logic          wave_a_o,
  output logic          wave_b_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_n, ra_q, rb_q;
  logic         down_q, down_n, wrap;
  logic         en_q, run_q, ext_q, capa_q, capb_q, out_a_q, out_b_q;
  logic [5:0]   sr_q;

  wire ext_edge = wave_mode_i & ext_i & ~ext_q;
  wire trig     = sw_trig_i | ext_edge;
  wire tick     = tick_i[clk_sel_i] & burst_i & en_q & run_q;
  wire step     = tick & ~trig;
  wire updown   = wave_mode_i & wave_sel_i[0];
  wire rc_mode  = wave_mode_i ? wave_sel_i[1] : rc_trg_i;
  wire at_rc    = rc_mode & (cnt_q == rc_i);
  wire cpa_ev   = step & wave_mode_i & (cnt_n == ra_i);
  wire cpb_ev   = step & wave_mode_i & (cnt_n == rb_i);
  wire cpc_ev   = step & (cnt_n == rc_i);
  wire ovf_ev   = step & wrap;
  wire lda_ev   = ~wave_mode_i & cap_a_i & ~capa_q;
  wire ldb_ev   = ~wave_mode_i & cap_b_i & ~capb_q;
  wire [5:0] ev = {ldb_ev, lda_ev, cpc_ev, cpb_ev, cpa_ev, ovf_ev};

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    wrap   = 1'b0;
    if (updown) begin
      if (!down_q) begin
        if (cnt_q == MAXV || at_rc) begin
          down_n = 1'b1;
          cnt_n  = cnt_q - 1'b1;
        end else begin
          cnt_n  = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        down_n = 1'b0;
        cnt_n  = cnt_q + 1'b1;
      end else begin
        cnt_n  = cnt_q - 1'b1;
      end
    end else if (at_rc) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
      wrap  = (cnt_q == MAXV);
    end
  end

  function automatic logic [1:0] pick(input logic [7:0] a, input logic s, input logic e,
                                      input logic c, input logic o);
    if (s && a[7:6] != 2'd0) return a[7:6];
    if (e && a[5:4] != 2'd0) return a[5:4];
    if (c && a[3:2] != 2'd0) return a[3:2];
    if (o) return a[1:0];
    return 2'd0;
  endfunction

  function automatic logic apply(input logic cur, input logic [1:0] code);
    case (code)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  wire [1:0] code_a = pick(act_a_i, sw_trig_i, ext_edge, cpc_ev, cpa_ev);
  wire [1:0] code_b = pick(act_b_i, sw_trig_i, ext_edge, cpc_ev, cpb_ev);
  wire       kill   = halt_i | (cpc_ev & rc_dis_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      down_q  <= 1'b0;
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      ext_q   <= 1'b0;
      capa_q  <= 1'b0;
      capb_q  <= 1'b0;
      ra_q    <= '0;
      rb_q    <= '0;
      sr_q    <= '0;
      out_a_q <= 1'b0;
      out_b_q <= 1'b0;
    end else begin
      ext_q  <= ext_i;
      capa_q <= cap_a_i;
      capb_q <= cap_b_i;
      if (trig) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
      end else if (tick) begin
        cnt_q  <= cnt_n;
        down_q <= down_n;
      end
      if (kill)         en_q <= 1'b0;
      else if (start_i) en_q <= 1'b1;
      if (kill)                       run_q <= 1'b0;
      else if (trig)                  run_q <= 1'b1;
      else if (cpc_ev && rc_stop_i)   run_q <= 1'b0;
      if (lda_ev) ra_q <= cnt_q;
      if (ldb_ev) rb_q <= cnt_q;
      sr_q <= (sr_rd_i ? 6'd0 : sr_q) | ev;
      if (wave_mode_i) begin
        out_a_q <= apply(out_a_q, code_a);
        out_b_q <= apply(out_b_q, code_b);
      end
    end
  end

  assign count_o   = cnt_q;
  assign cap_ra_o  = ra_q;
  assign cap_rb_o  = rb_q;
  assign status_o  = sr_q;
  assign clk_run_o = en_q & run_q;
  assign wave_a_o  = out_a_q;
  assign wave_b_o  = out_b_q;

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (count_o == '0));

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_i && !trig) |=> $stable(count_o));

  // R7
  cap_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lda_ev |=> (cap_ra_o == $past(count_o)));

  // R5
  turn_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && !down_q && count_o == MAXV && step) |=> (count_o == MAXV - 1'b1));

  // R12
  read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_i && ovf_ev) |=> status_o[0]);

  // R9
  rc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpc_ev && rc_stop_i) |=> !clk_run_o);

endmodule

// File: tb/test_wave_timer.sv
module test_wave_timer;
  localparam int W = 16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] tick_i = '0;
  logic [1:0] clk_sel_i = '0;
  logic burst_i = 1'b1, start_i = 1'b0, halt_i = 1'b0, sw_trig_i = 1'b0, ext_i = 1'b0;
  logic cap_a_i = 1'b0, cap_b_i = 1'b0, wave_mode_i = 1'b1;
  logic [1:0] wave_sel_i = '0;
  logic rc_trg_i = 1'b0, rc_stop_i = 1'b0, rc_dis_i = 1'b0, sr_rd_i = 1'b0;
  logic [W-1:0] ra_i = 16'd100, rb_i = 16'd200, rc_i = 16'd300;
  logic [7:0] act_a_i = '0, act_b_i = '0;
  logic [W-1:0] count_o, cap_ra_o, cap_rb_o;
  logic [5:0] status_o;
  logic clk_run_o, wave_a_o, wave_b_o;

  wave_timer #(.W(W), .NCLK(4)) i_wave_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clk_sel_i(clk_sel_i), .burst_i(burst_i),
    .start_i(start_i), .halt_i(halt_i), .sw_trig_i(sw_trig_i), .ext_i(ext_i),
    .cap_a_i(cap_a_i), .cap_b_i(cap_b_i), .wave_mode_i(wave_mode_i), .wave_sel_i(wave_sel_i),
    .rc_trg_i(rc_trg_i), .rc_stop_i(rc_stop_i), .rc_dis_i(rc_dis_i),
    .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i), .act_a_i(act_a_i), .act_b_i(act_b_i),
    .sr_rd_i(sr_rd_i), .count_o(count_o), .cap_ra_o(cap_ra_o), .cap_rb_o(cap_rb_o),
    .status_o(status_o), .clk_run_o(clk_run_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o));

  int checks = 0, errors = 0, cyc = 0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      summary();
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_i = 4'b0001;
    repeat (n) step();
    tick_i = '0;
  endtask

  task automatic trig();
    sw_trig_i = 1'b1; step(); sw_trig_i = 1'b0;
  endtask

  task automatic rd();
    sr_rd_i = 1'b1; step(); sr_rd_i = 1'b0;
  endtask

  // {act_a[7:0], sw, ext, expected wave_a}
  localparam logic [10:0] VEC [8] = '{
    {8'h40, 1'b1, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b0, 1'b0},
    {8'hC0, 1'b1, 1'b0, 1'b1},
    {8'h20, 1'b0, 1'b1, 1'b0},
    {8'h60, 1'b1, 1'b1, 1'b1},
    {8'h30, 1'b1, 1'b1, 1'b0},
    {8'hD0, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 count", count_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 outputs", {wave_a_o, wave_b_o, clk_run_o}, 0);
    chk("R1 captures", {cap_ra_o, cap_rb_o}, 0);

    start_i = 1'b1; step(); start_i = 1'b0;
    trig();
    chk("R6 start", clk_run_o, 1);
    tick_i = 4'b0010; repeat (4) step(); tick_i = '0;
    chk("R2 unselected tick", count_o, 0);
    ticks(3);
    chk("R2 count", count_o, 3);
    clk_sel_i = 2'd1; tick_i = 4'b0010; repeat (2) step(); tick_i = '0; clk_sel_i = 2'd0;
    chk("R2 select", count_o, 5);
    burst_i = 1'b0; ticks(5); burst_i = 1'b1;
    chk("R3 burst hold", count_o, 5);

    for (int i = 0; i < 8; i++) begin
      act_a_i = VEC[i][10:3]; sw_trig_i = VEC[i][2]; ext_i = VEC[i][1];
      step();
      sw_trig_i = 1'b0; ext_i = 1'b0;
      chk("R10 R11 action table", wave_a_o, VEC[i][0]);
      if (i == 0) chk("R6 trigger clears", count_o, 0);
      step();
    end
    act_a_i = '0;

    trig(); rd();
    ticks(65535);
    chk("R2 reach max", count_o, 16'hFFFF);
    chk("R4 no early ovf", status_o[0], 0);
    ticks(1);
    chk("R4 wrap", count_o, 0);
    chk("R4 ovf flag", status_o[0], 1);
    chk("R8 compares passed", status_o[3:1], 3'b111);

    ra_i = 16'd5; trig(); ticks(4);
    tick_i = 4'b0001; sr_rd_i = 1'b1; step(); tick_i = '0; sr_rd_i = 1'b0;
    chk("R12 read keeps new flag", status_o, 6'b000010);
    rd();
    chk("R12 read clears", status_o, 0);
    ra_i = 16'd0; trig();
    chk("R8 trigger no compare", status_o, 0);

    wave_sel_i = 2'd2; rc_i = 16'd6; ra_i = 16'd3;
    act_a_i = 8'h06; act_b_i = 8'h0C;
    ticks(3);
    chk("R10 compare A clear", wave_a_o, 0);
    ticks(3);
    chk("R10 RC set", wave_a_o, 1);
    chk("R10 RC toggle B", wave_b_o, 1);
    chk("R4 RC flag", status_o[3], 1);
    ticks(1);
    chk("R4 RC restart", count_o, 0);
    ra_i = 16'd6; act_a_i = 8'h09;
    ticks(6);
    chk("R11 RC over A", wave_a_o, 0);
    chk("R10 toggle back B", wave_b_o, 0);
    act_a_i = '0; act_b_i = '0;

    ra_i = 16'd100; rc_i = 16'd4; rc_stop_i = 1'b1;
    trig(); rd();
    ticks(6);
    chk("R9 stop count", count_o, 4);
    chk("R9 stopped", clk_run_o, 0);
    rd(); trig(); ticks(1);
    chk("R9 restart count", count_o, 1);
    chk("R8 no spurious flag", status_o, 0);
    rc_stop_i = 1'b0; rc_dis_i = 1'b1;
    ticks(3);
    chk("R9 disable count", count_o, 4);
    trig();
    chk("R9 disabled stays off", clk_run_o, 0);
    rc_dis_i = 1'b0;
    start_i = 1'b1; step(); start_i = 1'b0;
    trig();
    chk("R9 re-enable", clk_run_o, 1);

    wave_sel_i = 2'd1; rc_i = 16'd300;
    trig(); rd();
    ticks(65535);
    chk("R5 reach max", count_o, 16'hFFFF);
    ticks(1);
    chk("R5 turn at max", count_o, 16'hFFFE);
    chk("R5 no ovf", status_o[0], 0);
    ticks(1);
    chk("R5 counting down", count_o, 16'hFFFD);
    trig();
    chk("R6 clear in up/down", count_o, 0);
    ticks(1);
    chk("R6 direction up", count_o, 1);

    wave_sel_i = 2'd3; rc_i = 16'd3;
    trig(); ticks(3);
    chk("R5 reach RC", count_o, 3);
    ticks(1);
    chk("R5 turn at RC", count_o, 2);
    ticks(2);
    chk("R5 reach zero", count_o, 0);
    ticks(1);
    chk("R5 turn at zero", count_o, 1);

    wave_mode_i = 1'b0; wave_sel_i = 2'd0; rc_i = 16'd10;
    trig(); rd(); ticks(7);
    burst_i = 1'b0; cap_a_i = 1'b1; step(); cap_a_i = 1'b0;
    chk("R7 capture with burst low", cap_ra_o, 7);
    chk("R7 load A flag", status_o[4], 1);
    burst_i = 1'b1;
    tick_i = 4'b0001; cap_b_i = 1'b1; step(); tick_i = '0; cap_b_i = 1'b0;
    chk("R7 capture with tick", cap_rb_o, 7);
    chk("R7 count moved", count_o, 8);
    chk("R7 load B flag", status_o[5], 1);
    rc_trg_i = 1'b1; ticks(2);
    chk("R4 capture mode at RC", count_o, 10);
    tick_i = 4'b0001; cap_a_i = 1'b1; step(); tick_i = '0; cap_a_i = 1'b0;
    chk("R7 capture at RC restart", cap_ra_o, 10);
    chk("R4 capture mode restart", count_o, 0);

    summary();
    $finish;
  end
endmodule